// File: doc/BRIEF.md
# Four-Level Wavelet Synthesis Engine

This block rebuilds one frame of signal samples from its wavelet coefficients. It takes the coarsest approximation together with the detail coefficients of every level, which may already have been thresholded to suppress noise. Level by level, it upsamples by two and passes both branches through a 4-tap orthogonal synthesis filter pair with periodic wrap at the frame edges. It then sums the two branches into the next finer approximation, until the full-length frame is rebuilt. All arithmetic is 16-bit two's complement with 9 fractional bits (Q6.9).

The whole coefficient frame arrives on one wide bus and is captured on a single-cycle `start`. A small controller then walks the levels from the deepest upward. In state IDLE it waits for `start`; IDLE goes to PAIR on an accepted start. PAIR produces one even/odd output pair per cycle and stays in PAIR until the last pair of the level, then goes to COMMIT. COMMIT copies the finished level back into the working array; it goes to PAIR for the next level, or to DONE after the finest level. DONE raises `done` for one cycle and always returns to IDLE. The rebuilt frame stays on `sample_out` until the next accepted start.

Top module: `idwt_synth`

## Requirements
- R1: After reset, `done` is low and every word of `sample_out` is zero.
- R2: When `start` is high at a clock edge in IDLE, the whole `coef_in` bus is captured. Word i sits at bits [16*i+15:16*i]. Words 0..N/16-1 hold the deepest approximation, followed by the deepest details, then each finer level's details, with the finest details in words N/2..N-1. Later changes on `coef_in` do not affect that frame.
- R3: A `start` pulse while a reconstruction is in progress is ignored: the running frame's result and its `done` timing are unchanged.
- R4: At a level whose approximation a and detail d have length M, output pair m (indices k-1 taken modulo M) is even = H0*a[m] + H2*a[m-1] + H3*d[m] + H1*d[m-1] and odd = H1*a[m] + H3*a[m-1] - H2*d[m] - H0*d[m-1].
- R5: The synthesis taps, in Q6.9 LSBs, are H0=247, H1=428, H2=115, H3=-66.
- R6: Each output word is the full-precision four-product sum, rounded once by adding 256 and shifting right arithmetically by 9, then saturated to [-32768, 32767].
- R7: Reconstruction runs exactly LEVELS levels. It starts from an approximation of length N>>LEVELS, doubles the length at each level and ends at N samples.
- R8: `done` is a one-cycle pulse, high in the cycle after the (N - (N>>LEVELS) + LEVELS)-th rising edge following the edge that captured `start` (34 for N=32, LEVELS=4). `sample_out` then holds the frame unchanged while no new start is accepted.
- R9: For coefficients produced by the matching periodic forward analysis, quantized to Q6.9 with details left unmodified, every output sample is within 20 LSB (about 0.04) of the original.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture coefficients and begin reconstruction (honoured only in IDLE) |
| coef_in | input | N_SAMPLES*16 | Coefficient frame, packed word per index |
| done | output | 1 | One-cycle pulse when the rebuilt frame is complete |
| sample_out | output | N_SAMPLES*16 | Reconstructed Q6.9 samples, packed word per index |

## Verification
The assertions assume that `rst_n` is driven low before the first clock and that `start`, `coef_in` and `rst_n` change only away from the rising edge. The index and sign checks in the datapath take for granted that the coefficient bus carries defined values at the edge where `start` is sampled. The stimulus drives every input on the falling edge and pulses `start` for exactly one cycle. It loads the bus fully before raising `start`, and it changes the bus or repeats `start` during a run only in the scenarios that probe capture and the busy case.

// File: rtl/idwt_pkg.sv
package idwt_pkg;

    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = 9;
    localparam int ACC_W    = 2 * SAMPLE_W + 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAIR,
        ST_COMMIT,
        ST_DONE
    } phase_t;

    // Orthonormal four-tap scaling filter, real form
    localparam real TAP0_R = 0.48296291314453416;
    localparam real TAP1_R = 0.83651630373780794;
    localparam real TAP2_R = 0.22414386804201339;
    localparam real TAP3_R = -0.12940952255126037;

    localparam acc_t ROUND_BIAS = ACC_W'(2 ** (FRAC_W - 1));
    localparam acc_t SAT_HI     = ACC_W'(2 ** (SAMPLE_W - 1) - 1);
    localparam acc_t SAT_LO     = -ACC_W'(2 ** (SAMPLE_W - 1));

    function automatic sample_t to_fixed(input real v);
        real scaled;
        scaled = v * real'(2 ** FRAC_W);
        return sample_t'($rtoi(scaled + ((scaled < 0.0) ? -0.5 : 0.5)));
    endfunction

    function automatic acc_t widen_mul(input sample_t x, input sample_t y);
        acc_t wx;
        acc_t wy;
        wx = x;
        wy = y;
        return wx * wy;
    endfunction

    function automatic sample_t round_sat(input acc_t acc);
        acc_t r;
        r = (acc + ROUND_BIAS) >>> FRAC_W;
        if (r > SAT_HI) begin
            r = SAT_HI;
        end else if (r < SAT_LO) begin
            r = SAT_LO;
        end
        return r[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/idwt_pair.sv
module idwt_pair
    import idwt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sample_t a_cur,
    input  sample_t a_prev,
    input  sample_t d_cur,
    input  sample_t d_prev,
    output sample_t y_even,
    output sample_t y_odd
);

    localparam sample_t K0 = to_fixed(TAP0_R);
    localparam sample_t K1 = to_fixed(TAP1_R);
    localparam sample_t K2 = to_fixed(TAP2_R);
    localparam sample_t K3 = to_fixed(TAP3_R);

    acc_t acc_even;
    acc_t acc_odd;

    always_comb begin
        acc_even = widen_mul(K0, a_cur) + widen_mul(K2, a_prev)
                 + widen_mul(K3, d_cur) + widen_mul(K1, d_prev);
        acc_odd  = widen_mul(K1, a_cur) + widen_mul(K3, a_prev)
                 - widen_mul(K2, d_cur) - widen_mul(K0, d_prev);
        y_even   = round_sat(acc_even);
        y_odd    = round_sat(acc_odd);
    end

    AST_EVEN_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_even >= 0) |-> (y_even >= 0)); // R6
    AST_ODD_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_odd < 0) |-> (y_odd <= 0)); // R6

endmodule

// File: rtl/idwt_ctrl.sv
module idwt_ctrl
    import idwt_pkg::*;
#(
    parameter int N_SAMPLES = 32,
    parameter int LEVELS    = 4,
    localparam int IDX_W    = $clog2(N_SAMPLES),
    localparam int LVL_W    = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] half_len_o,
    output logic             capture_o,
    output logic             pair_we_o,
    output logic             commit_o,
    output logic             idle_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] BASE_LEN = IDX_W'(N_SAMPLES >> LEVELS);

    phase_t           state_q;
    phase_t           state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] half_len_q;
    logic [LVL_W-1:0] lvl_q;
    logic             last_pair;
    logic             last_level;

    assign last_pair  = (idx_q == half_len_q - IDX_W'(1));
    assign last_level = (lvl_q == LVL_W'(1));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_PAIR : ST_IDLE;
            ST_PAIR:   state_d = last_pair ? ST_COMMIT : ST_PAIR;
            ST_COMMIT: state_d = last_level ? ST_DONE : ST_PAIR;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with level and pair counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            half_len_q <= '0;
            lvl_q      <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q      <= '0;
                        half_len_q <= BASE_LEN;
                        lvl_q      <= LVL_W'(LEVELS);
                    end
                end
                ST_PAIR: begin
                    idx_q <= idx_q + IDX_W'(1);
                end
                ST_COMMIT: begin
                    idx_q      <= '0;
                    half_len_q <= half_len_q << 1;
                    lvl_q      <= lvl_q - LVL_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        capture_o  = 1'b0;
        pair_we_o  = 1'b0;
        commit_o   = 1'b0;
        idle_o     = 1'b0;
        done_o     = 1'b0;
        idx_o      = idx_q;
        half_len_o = half_len_q;
        unique case (state_q)
            ST_IDLE: begin
                idle_o    = 1'b1;
                capture_o = start;
            end
            ST_PAIR:   pair_we_o = 1'b1;
            ST_COMMIT: commit_o  = 1'b1;
            ST_DONE:   done_o    = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(commit_o)); // R7
    AST_PAIR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we_o |-> (idx_q < half_len_q)); // R4
    AST_LEN_DOUBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !last_level) |=> (half_len_q == ($past(half_len_q) << 1))); // R7
    AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we_o || commit_o) |=> !$rose(idle_o) || $past(commit_o)); // R3

endmodule

// File: rtl/idwt_synth.sv
module idwt_synth
    import idwt_pkg::*;
#(
    parameter int N_SAMPLES = 32,
    parameter int LEVELS    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [N_SAMPLES*SAMPLE_W-1:0] coef_in,
    output logic                         done,
    output logic [N_SAMPLES*SAMPLE_W-1:0] sample_out
);

    localparam int IDX_W = $clog2(N_SAMPLES);

    sample_t          coef_word [N_SAMPLES];
    sample_t          work_q    [N_SAMPLES];
    sample_t          stage_q   [N_SAMPLES];

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] half_len;
    logic             capture;
    logic             pair_we;
    logic             commit;
    logic             idle;

    logic [IDX_W-1:0] prev_idx;
    logic [IDX_W-1:0] det_cur;
    logic [IDX_W-1:0] det_prev;
    logic [IDX_W-1:0] even_slot;
    logic [IDX_W-1:0] odd_slot;
    sample_t          y_even;
    sample_t          y_odd;

    generate
        for (genvar g = 0; g < N_SAMPLES; g++) begin : g_word
            assign coef_word[g] = coef_in[g*SAMPLE_W +: SAMPLE_W];
            assign sample_out[g*SAMPLE_W +: SAMPLE_W] = work_q[g];
        end
    endgenerate

    idwt_ctrl #(
        .N_SAMPLES (N_SAMPLES),
        .LEVELS    (LEVELS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .idx_o      (idx),
        .half_len_o (half_len),
        .capture_o  (capture),
        .pair_we_o  (pair_we),
        .commit_o   (commit),
        .idle_o     (idle),
        .done_o     (done)
    );

    // Periodic neighbour and detail addressing
    always_comb begin
        prev_idx  = (idx == '0) ? (half_len - IDX_W'(1)) : (idx - IDX_W'(1));
        det_cur   = half_len + idx;
        det_prev  = half_len + prev_idx;
        even_slot = IDX_W'({idx, 1'b0});
        odd_slot  = IDX_W'({idx, 1'b1});
    end

    idwt_pair u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_cur  (work_q[idx]),
        .a_prev (work_q[prev_idx]),
        .d_cur  (work_q[det_cur]),
        .d_prev (work_q[det_prev]),
        .y_even (y_even),
        .y_odd  (y_odd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SAMPLES; i++) begin
                work_q[i]  <= '0;
                stage_q[i] <= '0;
            end
        end else begin
            if (capture) begin
                for (int i = 0; i < N_SAMPLES; i++) begin
                    work_q[i] <= coef_word[i];
                end
            end else if (commit) begin
                for (int i = 0; i < N_SAMPLES; i++) begin
                    if (i < 2 * int'(half_len)) begin
                        work_q[i] <= stage_q[i];
                    end
                end
            end
            if (pair_we) begin
                stage_q[even_slot] <= y_even;
                stage_q[odd_slot]  <= y_odd;
            end
        end
    end

    AST_OUT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> $stable(sample_out)); // R8
    AST_DETAIL_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |-> (int'(det_cur) < N_SAMPLES) && (det_cur >= half_len)); // R4

endmodule

// File: tb/idwt_synth_tb.sv
`timescale 1ns/1ps
module idwt_synth_tb;

    localparam int N   = 32;
    localparam int LV  = 4;
    localparam int W   = 16;
    localparam int LAT = (N - (N >> LV)) + LV;
    localparam int TOL = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N*W-1:0] coef_in = '0;
    logic          done;
    logic [N*W-1:0] sample_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int coef [N];
    int expv [N];
    int orig [N];

    idwt_synth #(.N_SAMPLES(N), .LEVELS(LV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .coef_in    (coef_in),
        .done       (done),
        .sample_out (sample_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int out_word(input int i);
        return int'($signed(sample_out[i*W +: W]));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_frame(input string req);
        int first;
        first = -1;
        for (int i = 0; i < N; i++) begin
            if (first < 0 && out_word(i) != expv[i]) first = i;
        end
        checks++;
        if (first >= 0) begin
            fails++;
            $display("FAIL %s word %0d: actual %0d expected %0d", req, first, out_word(first), expv[first]);
        end
    endtask

    function automatic int qsat(input int s);
        int r;
        r = (s + 256) >>> 9;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Expected frame from R4, R5, R6, R7
    task automatic model_ref();
        int a [N];
        int nx [N];
        int m_len;
        for (int i = 0; i < N; i++) a[i] = coef[i];
        m_len = N >> LV;
        for (int l = 0; l < LV; l++) begin
            for (int m = 0; m < m_len; m++) begin
                int mp;
                mp = (m == 0) ? m_len - 1 : m - 1;
                nx[2*m]   = qsat(247*a[m] + 115*a[mp] - 66*a[m_len+m] + 428*a[m_len+mp]);
                nx[2*m+1] = qsat(428*a[m] - 66*a[mp] - 115*a[m_len+m] - 247*a[m_len+mp]);
            end
            for (int i = 0; i < 2*m_len; i++) a[i] = nx[i];
            m_len = m_len * 2;
        end
        for (int i = 0; i < N; i++) expv[i] = a[i];
    endtask

    task automatic drive_coef();
        for (int i = 0; i < N; i++) coef_in[i*W +: W] = W'(coef[i]);
    endtask

    task automatic run_frame(output int lat);
        @(negedge clk);
        drive_coef();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
    endtask

    task automatic check_pulse_end();
        @(posedge clk);
        @(negedge clk);
        check("R8", "done falls after one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        int nz;
        nz = 0;
        for (int i = 0; i < N; i++) if (out_word(i) != 0) nz++;
        check("R1", "done after reset", int'(done), 0);
        check("R1", "nonzero output words after reset", nz, 0);
    endtask

    task automatic t_impulse(input int pos, input int val, input string req);
        int lat;
        for (int i = 0; i < N; i++) coef[i] = 0;
        coef[pos] = val;
        model_ref();
        run_frame(lat);
        check("R8", "latency", lat, LAT);
        check_frame(req);
        check_pulse_end();
    endtask

    task automatic t_random(input int frames);
        int lat;
        for (int f = 0; f < frames; f++) begin
            for (int i = 0; i < N; i++) coef[i] = int'($urandom_range(8192, 0)) - 4096;
            model_ref();
            run_frame(lat);
            check("R8", "latency random frame", lat, LAT);
            check_frame("R4");
        end
    endtask

    task automatic t_saturate(input int val);
        int lat;
        int hits;
        for (int i = 0; i < N; i++) coef[i] = val;
        model_ref();
        hits = 0;
        for (int i = 0; i < N; i++) if (expv[i] == 32767 || expv[i] == -32768) hits++;
        check("R6", "saturating scenario reaches a rail", int'(hits > 0), 1);
        run_frame(lat);
        check_frame("R6");
    endtask

    task automatic t_hold();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) coef_in[i*W +: W] = W'($urandom);
        end
        @(posedge clk);
        @(negedge clk);
        check("R8", "done stays low while idle", int'(done), 0);
        check_frame("R8");
    endtask

    task automatic t_busy();
        int lat;
        for (int i = 0; i < N; i++) coef[i] = int'($urandom_range(4096, 0)) - 2048;
        model_ref();
        @(negedge clk);
        drive_coef();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        // R2: bus changes after capture; R3: start repeated mid-run
        for (int i = 0; i < N; i++) coef_in[i*W +: W] = W'($urandom);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 200) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check("R3", "latency with start while busy", lat, LAT);
        check_frame("R2");
        check_pulse_end();
        check("R3", "no second frame started", int'(done), 0);
    endtask

    task automatic t_recon(input int frames);
        real s3;
        real den;
        real hr [4];
        real gr [4];
        real xr [N];
        real tr [N];
        int len;
        int lat;
        int maxerr;
        s3  = $sqrt(3.0);
        den = 4.0 * $sqrt(2.0);
        hr[0] = (1.0 + s3) / den;
        hr[1] = (3.0 + s3) / den;
        hr[2] = (3.0 - s3) / den;
        hr[3] = (1.0 - s3) / den;
        gr[0] = hr[3];
        gr[1] = -hr[2];
        gr[2] = hr[1];
        gr[3] = -hr[0];
        for (int f = 0; f < frames; f++) begin
            for (int i = 0; i < N; i++) begin
                orig[i] = int'($urandom_range(2048, 0)) - 1024;
                xr[i]   = real'(orig[i]);
            end
            len = N;
            for (int l = 0; l < LV; l++) begin
                for (int k = 0; k < len/2; k++) begin
                    real av;
                    real dv;
                    av = 0.0;
                    dv = 0.0;
                    for (int j = 0; j < 4; j++) begin
                        av += hr[j] * xr[(2*k + j) % len];
                        dv += gr[j] * xr[(2*k + j) % len];
                    end
                    tr[k]         = av;
                    tr[len/2 + k] = dv;
                end
                for (int i = 0; i < len; i++) xr[i] = tr[i];
                len = len / 2;
            end
            for (int i = 0; i < N; i++) coef[i] = $rtoi($floor(xr[i] + 0.5));
            run_frame(lat);
            maxerr = 0;
            for (int i = 0; i < N; i++) begin
                int e;
                e = out_word(i) - orig[i];
                if (e < 0) e = -e;
                if (e > maxerr) maxerr = e;
            end
            checks++;
            if (maxerr > TOL) begin
                fails++;
                $display("FAIL R9 reconstruction error: actual %0d LSB expected at most %0d", maxerr, TOL);
            end
        end
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_impulse(0, 512, "R5");
        t_impulse(1, -700, "R7");
        t_impulse(3, 512, "R7");
        t_impulse(N/2 + 5, 1000, "R4");
        t_random(4);
        t_hold();
        t_saturate(32767);
        t_saturate(-32768);
        t_busy();
        t_recon(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule